// File: doc/BRIEF.md
# Bidirectional GPIO Port with External-Bus Override

The block controls an 8-bit (parameterised) bidirectional pad group. Software reaches it through a small register request/response interface with four word addresses: the sampled pin levels, the output latch, the per-pin direction mask and a control word. The block drives the tri-state pad controls `pad_out` and `pad_oe`. It brings the asynchronous pad inputs through a two-flop synchronizer before anything can read them.

An external memory bus can claim the pads. While `bus_disable` is low, the bus output enable and bus data drive the pads, and the direction and latch registers keep their contents. A slave-mode flag stored in the control word is presented as a plain status output and has no other effect.

Requests use valid/ready. A request is accepted on a rising edge with `req_valid` and `req_ready` both high. Writes produce no response. Each accepted read loads a response register one cycle later. `req_ready` is low only while a response is pending and `rsp_ready` is low. A pending response holds its data until it is taken with `rsp_ready` high.

Top module: `gpio_port`

## Requirements
- R1: After reset every direction bit is 1 (all pins inputs), the latch is 0x00, the slave flag is 0 and no response is pending. With `bus_disable`=1, `pad_oe` is 0x00.
- R2: With `bus_disable`=1, pin i is driven (`pad_oe[i]`=1) exactly when direction bit i is 0, and `pad_out[i]` equals latch bit i. Every pin is configured independently.
- R3: A read of address 1 returns the latch contents, not the pin levels. A read of address 2 returns the direction mask.
- R4: A read of address 0, and the `bus_rdata` output, show `pad_in` through a two-flop synchronizer. A read accepted one or two edges after a pin change returns the old level. A read accepted three edges after the change returns the new level.
- R5: A write to address 0 or to address 1 loads the latch. A write to address 2 loads the direction mask.
- R6: With `bus_disable`=0, every bit of `pad_oe` equals `bus_oe` and `pad_out` equals `bus_dout`. Direction and latch contents are unchanged by the takeover and apply again when `bus_disable` returns to 1.
- R7: A write to address 3 stores bit 4 of the data as the slave flag on `slave_mode`. A read of address 3 returns that flag at bit 4 and zeros elsewhere.
- R8: While a response is pending and `rsp_ready` is low, `rsp_valid` stays 1, `rsp_rdata` stays stable and `req_ready` is 0. A request offered during that time is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | 0 pins, 1 latch, 2 direction, 3 control |
| req_wdata | input | W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_rdata | output | W | Read response data |
| pad_in | input | W | Raw pad input levels |
| pad_out | output | W | Pad output value |
| pad_oe | output | W | Pad output enable, 1 = drive |
| bus_disable | input | 1 | 1 = register-controlled I/O, 0 = external bus owns pads |
| bus_oe | input | 1 | External bus output enable |
| bus_dout | input | W | External bus low address/data byte |
| bus_rdata | output | W | Synchronized pin levels for the external bus |
| slave_mode | output | 1 | Slave-mode status flag |

## Verification
The bench sweeps all 256 direction masks with varied latch patterns. A decoder that inverted the direction sense, or shifted or swapped bits, would give a wrong `pad_oe` for some mask. It drives the pins to the inverse of the latch and then reads the latch, which catches a design that returns pin levels for a latch read and so breaks read-modify-write.

The bench reads the pins one, two and three edges after a change. A synchronizer that is one stage short or one stage long would return the new level too early or too late. It takes the pads over with the bus, writes nothing, and then hands them back, which catches a takeover that corrupts or clears the registers. It also holds a response with `rsp_ready` low while it offers a write, and would see a lost response or a write that slips through under back-pressure.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  typedef enum logic [1:0] {
    ADDR_PINS  = 2'd0,
    ADDR_LATCH = 2'd1,
    ADDR_DIR   = 2'd2,
    ADDR_CTRL  = 2'd3
  } gp_addr_e;

  // position of the slave-mode flag inside the control word
  localparam int SLAVE_BIT = 4;
endpackage

// File: rtl/gpio_port_sync.sv
`timescale 1ns/1ps
module gpio_port_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pin_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1   <= '0;
      pin_sync <= '0;
    end else begin
      stage1   <= pad_in;
      pin_sync <= stage1;
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] latch_q,
  output logic         slave_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '1;   // every pin starts as an input
      latch_q <= '0;
      slave_q <= 1'b0;
    end else if (wr_en) begin
      case (gp_addr_e'(wr_addr))
        ADDR_PINS, ADDR_LATCH: latch_q <= wr_data;
        ADDR_DIR:              dir_q   <= wr_data;
        ADDR_CTRL:             slave_q <= wr_data[SLAVE_BIT];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_rsp.sv
`timescale 1ns/1ps
module gpio_port_rsp
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_fire,
  input  logic [1:0]   rd_addr,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  input  logic         slave_q,
  input  logic         rsp_ready,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_rdata
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    case (gp_addr_e'(rd_addr))
      ADDR_PINS:  sel = pin_sync;
      ADDR_LATCH: sel = latch_q;
      ADDR_DIR:   sel = dir_q;
      ADDR_CTRL:  sel[SLAVE_BIT] = slave_q;
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= sel;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_port_padmux.sv
`timescale 1ns/1ps
module gpio_port_padmux #(
  parameter int W = 8
) (
  input  logic         bus_disable,
  input  logic         bus_oe,
  input  logic [W-1:0] bus_dout,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] latch_q,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // direction bit 1 = input, so the driver is enabled by its inverse
    assign pad_oe[i]  = bus_disable ? ~dir_q[i]  : bus_oe;
    assign pad_out[i] = bus_disable ? latch_q[i] : bus_dout[i];
  end
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_write,
  input  logic [1:0]   req_addr,
  input  logic [W-1:0] req_wdata,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  input  logic         bus_disable,
  input  logic         bus_oe,
  input  logic [W-1:0] bus_dout,
  output logic [W-1:0] bus_rdata,
  output logic         slave_mode
);
  logic         req_fire;
  logic         wr_fire;
  logic         rd_fire;
  logic [W-1:0] pin_sync;
  logic [W-1:0] dir_q;
  logic [W-1:0] latch_q;
  logic         slave_q;

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign wr_fire   = req_fire && req_write;
  assign rd_fire   = req_fire && !req_write;

  gpio_port_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .pin_sync (pin_sync)
  );

  gpio_port_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire),
    .wr_addr (req_addr),
    .wr_data (req_wdata),
    .dir_q   (dir_q),
    .latch_q (latch_q),
    .slave_q (slave_q)
  );

  gpio_port_rsp #(.W(W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_fire),
    .rd_addr   (req_addr),
    .pin_sync  (pin_sync),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .slave_q   (slave_q),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  gpio_port_padmux #(.W(W)) u_padmux (
    .bus_disable (bus_disable),
    .bus_oe      (bus_oe),
    .bus_dout    (bus_dout),
    .dir_q       (dir_q),
    .latch_q     (latch_q),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe)
  );

  assign bus_rdata  = pin_sync;
  assign slave_mode = slave_q;
endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic         req_write,
  input logic [1:0]   req_addr,
  input logic [W-1:0] req_wdata,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [W-1:0] rsp_rdata,
  input logic [W-1:0] pad_oe,
  input logic         bus_disable,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] latch_q,
  input logic [W-1:0] pin_sync,
  input logic         slave_mode
);
  logic acc_wr;
  logic acc_rd;
  assign acc_wr = req_valid && req_ready && req_write;
  assign acc_rd = req_valid && req_ready && !req_write;

  AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && bus_disable) |-> (pad_oe == '0)); // R1

  AST_INPUT_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_disable |-> ((pad_oe & dir_q) == '0)); // R2

  AST_PORT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && req_addr == 2'd0) |=> (rsp_valid && rsp_rdata == $past(pin_sync))); // R4

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_wr && req_addr[1] == 1'b0) |=> $stable(latch_q)); // R5

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_wr && req_addr == 2'd2) |=> $stable(dir_q)); // R6

  AST_SLAVE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && req_addr == 2'd3) |=> (slave_mode == $past(req_wdata[4]))); // R7

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R8
endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .pad_oe      (pad_oe),
  .bus_disable (bus_disable),
  .dir_q       (dir_q),
  .latch_q     (latch_q),
  .pin_sync    (pin_sync),
  .slave_mode  (slave_mode)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [1:0]   req_addr = 2'd0;
  logic [W-1:0] req_wdata = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [W-1:0] rsp_rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out;
  logic [W-1:0] pad_oe;
  logic         bus_disable = 1'b1;
  logic         bus_oe = 1'b0;
  logic [W-1:0] bus_dout = '0;
  logic [W-1:0] bus_rdata;
  logic         slave_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .bus_disable(bus_disable), .bus_oe(bus_oe), .bus_dout(bus_dout),
    .bus_rdata(bus_rdata), .slave_mode(slave_mode)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  // change pins, let 'gap' edges pass, then have a read accepted on the next edge
  task automatic rd_after(input logic [7:0] pins, input int gap, output logic [7:0] d);
    @(negedge clk);
    pad_in = pins;
    repeat (gap) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 00 expected 01");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] lv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pad_oe == 8'h00, "R1 pad_oe", pad_oe, 8'h00);
    chk(pad_out == 8'h00, "R1 pad_out", pad_out, 8'h00);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", {7'd0, rsp_valid}, 8'h00);
    chk(slave_mode == 1'b0, "R1 slave", {7'd0, slave_mode}, 8'h00);
    rd(2'd2, r); chk(r == 8'hFF, "R1 dir", r, 8'hFF);
    rd(2'd1, r); chk(r == 8'h00, "R1 latch", r, 8'h00);
    rd(2'd3, r); chk(r == 8'h00, "R1 ctrl", r, 8'h00);

    // R2/R5 sweep over every direction mask, alternating latch address
    for (int d = 0; d < 256; d++) begin
      lv = 8'(d) ^ 8'h5A ^ 8'(d << 3);
      wr(2'd2, 8'(d));
      wr((d % 2 == 0) ? 2'd0 : 2'd1, lv);
      @(negedge clk);
      chk(pad_oe == ~8'(d), "R2 pad_oe", pad_oe, ~8'(d));
      chk(pad_out == lv, "R5 pad_out latch", pad_out, lv);
      if (d % 16 == 3) begin
        // R3 pins opposite to latch must not show in latch read
        pad_in = ~lv;
        repeat (3) @(negedge clk);
        rd(2'd1, r); chk(r == lv, "R3 latch read", r, lv);
        rd(2'd2, r); chk(r == 8'(d), "R3 dir read", r, 8'(d));
      end
    end

    // R4 sweep over every pin pattern
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      pad_in = 8'(p);
      repeat (2) @(negedge clk);
      rd(2'd0, r);
      chk(r == 8'(p), "R4 pin read", r, 8'(p));
      chk(bus_rdata == 8'(p), "R4 bus_rdata", bus_rdata, 8'(p));
    end

    // R4 synchronizer latency
    for (int g = 0; g < 3; g++) begin
      @(negedge clk); pad_in = 8'h00; repeat (4) @(negedge clk);
      rd_after(8'hFF, g, r);
      chk(r == ((g == 2) ? 8'hFF : 8'h00), "R4 latency", r, (g == 2) ? 8'hFF : 8'h00);
    end

    // R6 bus ownership
    wr(2'd2, 8'h0F);
    wr(2'd1, 8'h33);
    @(negedge clk);
    bus_disable = 1'b0; bus_oe = 1'b1; bus_dout = 8'hA5;
    @(negedge clk);
    chk(pad_oe == 8'hFF, "R6 bus oe on", pad_oe, 8'hFF);
    chk(pad_out == 8'hA5, "R6 bus data", pad_out, 8'hA5);
    bus_oe = 1'b0; bus_dout = 8'h3C;
    @(negedge clk);
    chk(pad_oe == 8'h00, "R6 bus oe off", pad_oe, 8'h00);
    chk(pad_out == 8'h3C, "R6 bus data2", pad_out, 8'h3C);
    repeat (3) @(negedge clk);
    bus_disable = 1'b1;
    @(negedge clk);
    chk(pad_oe == 8'hF0, "R6 return oe", pad_oe, 8'hF0);
    chk(pad_out == 8'h33, "R6 return out", pad_out, 8'h33);
    rd(2'd1, r); chk(r == 8'h33, "R6 latch kept", r, 8'h33);
    rd(2'd2, r); chk(r == 8'h0F, "R6 dir kept", r, 8'h0F);

    // R7 slave flag
    wr(2'd3, 8'hFF);
    @(negedge clk);
    chk(slave_mode == 1'b1, "R7 slave set", {7'd0, slave_mode}, 8'h01);
    rd(2'd3, r); chk(r == 8'h10, "R7 ctrl read", r, 8'h10);
    wr(2'd3, 8'hEF);
    @(negedge clk);
    chk(slave_mode == 1'b0, "R7 slave clr", {7'd0, slave_mode}, 8'h00);
    rd(2'd3, r); chk(r == 8'h00, "R7 ctrl read0", r, 8'h00);

    // R8 back-pressure
    wr(2'd2, 8'h00);
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(2'd1, r);
    chk(r == 8'h33, "R8 read", r, 8'h33);
    chk(req_ready == 1'b0, "R8 req_ready low", {7'd0, req_ready}, 8'h00);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 2'd1; req_wdata = 8'h99;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b1, "R8 rsp held", {7'd0, rsp_valid}, 8'h01);
    chk(rsp_rdata == 8'h33, "R8 data held", rsp_rdata, 8'h33);
    chk(pad_out == 8'h33, "R8 write blocked", pad_out, 8'h33);
    req_valid = 1'b0; req_write = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 rsp drained", {7'd0, rsp_valid}, 8'h00);
    chk(pad_out == 8'h33, "R8 latch after", pad_out, 8'h33);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule